// File: doc/BRIEF.md
# Serial Interrupt Host Frame Controller

This block is the host end of a single shared, open-drain style serialized interrupt wire. It frames each interrupt cycle: a start pulse, a run of fixed three-clock data slots in which agents report their interrupt levels, and a stop pulse whose width announces the mode of the next cycle. From the levels it reads back in the slots, it builds a vector with one bit per interrupt line.

Two framing modes exist. In continuous mode the host owns every start and opens a new cycle right after each stop. In quiet mode the wire rests released until some agent pulls it low for one clock. The host then takes over the start on the next clock and stretches the pulse to a programmable total width. The mode input is only taken into account at the one clock edge that opens a stop frame. The wire drivers, the pull-up and the interrupt controller sit outside the block.

Top module: `sirq_host_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the line output-enable is 0 and the IRQ vector is all ones. Reset leaves the block in continuous mode, so the host opens the first cycle on its own.
- R2: A start the host opens itself drives the line low (output-enable 1, value 0) for E+1 clocks, where E is the effective extension. This is followed by exactly one clock driven high (output-enable 1, value 1), after which the line is released.
- R3: The extension input is 3 bits wide. E equals its value for 3..7, and codes 0, 1 and 2 are treated as 3, so the low part of a start lasts at most 8 clocks and at least 4.
- R4: In quiet mode, while the line rests released, a 0 on the sampled line makes the host drive it low starting with the very next clock. The host holds it low for E clocks, which gives a total pulse of E+1 clocks counting the agent's clock, then drives it high for one clock and releases it.
- R5: Number the start's high clock as t=0. The line stays released for t=1 up to t=3S+1 (S = slot count, default 16), and the sample phase of slot N (1..S) is the clock t=3N-1.
- R6: Bit N-1 of the vector takes the sampled line value from the sample phase of slot N: 0 means the IRQ is low, 1 means high. Lows seen in recovery or turn-around clocks have no effect.
- R7: The vector changes only at the edge that ends t=3S+1, so the new value first shows in the first clock of the stop frame. At all other times it holds.
- R8: The stop frame begins at t=3S+2. It drives the line low for 2 clocks in quiet mode or 3 clocks in continuous mode, then high for one clock, then releases it.
- R9: The mode input (1 = quiet, 0 = continuous) is captured only at the edge ending t=3S+1. That captured value sets both the stop width and what follows the stop. A change to the input at any other clock has no effect.
- R10: In continuous mode the next start's low pulse begins in the clock right after the stop's high clock.
- R11: In quiet mode the line stays released after a stop until a low is sampled, and no host start occurs during that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the serial interrupt wire |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Synchronized level read back from the wire |
| start_ext_i | input | EXT_W (3) | Start low extension; values below 3 act as 3 |
| quiet_mode_i | input | 1 | Requested mode for the next cycle: 1 quiet, 0 continuous |
| line_oe_o | output | 1 | Host drives the wire when 1 |
| line_out_o | output | 1 | Level driven while line_oe_o is 1 |
| irq_vec_o | output | NSLOT (16) | Per-slot IRQ levels of the last completed cycle |

## Verification
The vector commit and the mode capture both fall on the edge that ends the last slot's turn-around clock. The bench provokes this collision by changing the mode input exactly in that clock while also presenting a new slot pattern. It then judges both effects: the vector must switch in the first stop clock, and the stop must have the width of the newly captured mode. As a counter-test, the mode input is also flipped in every other clock of a cycle, and the bench requires the previous stop width and the previous follow-up to remain.

// File: rtl/sirq_host_pkg.sv
package sirq_host_pkg;

    // Frame sequencer states of the host
    typedef enum logic [2:0] {
        ST_IDLE,      // line released, waiting (quiet mode) or about to start
        ST_START,     // host drives the start pulse low
        ST_START_HI,  // one clock driven high, start rising edge
        ST_SLOTS,     // line released while data slots run
        ST_STOP_LO,   // stop pulse low
        ST_STOP_HI    // one clock driven high after the stop
    } sirq_state_e;

    // Smallest low extension accepted from the programming field
    localparam int unsigned EXT_MIN = 3;

    // Stop low widths announcing the next cycle's mode
    localparam int unsigned STOP_QUIET = 2;
    localparam int unsigned STOP_CONT  = 3;

endpackage

// File: rtl/sirq_frame_fsm.sv
module sirq_frame_fsm
    import sirq_host_pkg::*;
#(
    parameter int EXT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [EXT_W-1:0] ext_i,
    input  logic             quiet_i,
    input  logic             last_i,
    output sirq_state_e      state_o,
    output logic             quiet_o,
    output logic             timer_run_o,
    output logic             commit_o,
    output logic             line_oe_o,
    output logic             line_out_o
);

    localparam int CW = EXT_W + 1;

    typedef struct packed {
        sirq_state_e   st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic          quiet;
    } fsm_regs_t;

    fsm_regs_t r_q, r_d;
    logic [CW-1:0] ext_eff;

    // Effective extension: short codes widen to the minimum
    always_comb begin
        if (ext_i < EXT_W'(EXT_MIN)) begin
            ext_eff = CW'(EXT_MIN);
        end else begin
            ext_eff = {1'b0, ext_i};
        end
    end

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!r_q.quiet) begin
                    r_d.st  = ST_START;
                    r_d.cnt = CW'(1);
                    r_d.len = ext_eff + CW'(1);
                end else if (!line_i) begin
                    // agent already supplied one low clock
                    r_d.st  = ST_START;
                    r_d.cnt = CW'(1);
                    r_d.len = ext_eff;
                end
            end
            ST_START: begin
                if (r_q.cnt == r_q.len) begin
                    r_d.st = ST_START_HI;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_START_HI: begin
                r_d.st = ST_SLOTS;
            end
            ST_SLOTS: begin
                if (last_i) begin
                    r_d.st    = ST_STOP_LO;
                    r_d.cnt   = CW'(1);
                    r_d.quiet = quiet_i;
                    r_d.len   = quiet_i ? CW'(STOP_QUIET) : CW'(STOP_CONT);
                end
            end
            ST_STOP_LO: begin
                if (r_q.cnt == r_q.len) begin
                    r_d.st = ST_STOP_HI;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_STOP_HI: begin
                if (r_q.quiet) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.st  = ST_START;
                    r_d.cnt = CW'(1);
                    r_d.len = ext_eff + CW'(1);
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.len   <= '0;
            r_q.quiet <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o     = r_q.st;
    assign quiet_o     = r_q.quiet;
    assign timer_run_o = (r_q.st == ST_START_HI) || (r_q.st == ST_SLOTS);
    assign commit_o    = (r_q.st == ST_SLOTS) && last_i;
    assign line_oe_o   = (r_q.st == ST_START) || (r_q.st == ST_START_HI) ||
                         (r_q.st == ST_STOP_LO) || (r_q.st == ST_STOP_HI);
    assign line_out_o  = (r_q.st == ST_START_HI) || (r_q.st == ST_STOP_HI);

endmodule

// File: rtl/sirq_slot_timer.sv
module sirq_slot_timer #(
    parameter int NSLOT = 16,
    parameter int SW    = $clog2(NSLOT + 1),
    parameter int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic          sample_o,
    output logic [IW-1:0] slot_o,
    output logic          last_o
);

    // phase encoding: 0 = sample, 1 = recovery, 2 = turn-around
    localparam logic [1:0] PH_SMP = 2'd0;
    localparam logic [1:0] PH_REC = 2'd1;
    localparam logic [1:0] PH_TA  = 2'd2;

    typedef struct packed {
        logic [1:0]    ph;
        logic [SW-1:0] slot;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            // the start's high clock acts as a recovery phase
            r_d.ph   = PH_REC;
            r_d.slot = '0;
        end else begin
            unique case (r_q.ph)
                PH_SMP: begin
                    r_d.ph   = PH_REC;
                    r_d.slot = r_q.slot + SW'(1);
                end
                PH_REC:  r_d.ph = PH_TA;
                default: r_d.ph = PH_SMP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph   <= PH_REC;
            r_q.slot <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sample_o = run_i && (r_q.ph == PH_SMP);
    assign slot_o   = r_q.slot[IW-1:0];
    assign last_o   = run_i && (r_q.ph == PH_TA) && (r_q.slot == SW'(NSLOT));

endmodule

// File: rtl/sirq_vec_capture.sv
module sirq_vec_capture #(
    parameter int NSLOT = 16,
    parameter int IW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic             sample_i,
    input  logic [IW-1:0]    slot_i,
    input  logic             commit_i,
    output logic [NSLOT-1:0] vec_o
);

    typedef struct packed {
        logic [NSLOT-1:0] shadow;
        logic [NSLOT-1:0] vec;
    } cap_regs_t;

    cap_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NSLOT; i++) begin
            if (sample_i && (slot_i == IW'(i))) begin
                r_d.shadow[i] = line_i;
            end
        end
        if (commit_i) begin
            r_d.vec = r_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.shadow <= '1;
            r_q.vec    <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign vec_o = r_q.vec;

endmodule

// File: rtl/sirq_host_ctrl.sv
module sirq_host_ctrl
    import sirq_host_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int EXT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    input  logic [EXT_W-1:0] start_ext_i,
    input  logic             quiet_mode_i,
    output logic             line_oe_o,
    output logic             line_out_o,
    output logic [NSLOT-1:0] irq_vec_o
);

    localparam int IW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    sirq_state_e   seq_state;
    logic          seq_quiet;
    logic          tmr_run;
    logic          tmr_sample;
    logic [IW-1:0] tmr_slot;
    logic          tmr_last;
    logic          vec_commit;

    sirq_frame_fsm #(
        .EXT_W (EXT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line_i),
        .ext_i       (start_ext_i),
        .quiet_i     (quiet_mode_i),
        .last_i      (tmr_last),
        .state_o     (seq_state),
        .quiet_o     (seq_quiet),
        .timer_run_o (tmr_run),
        .commit_o    (vec_commit),
        .line_oe_o   (line_oe_o),
        .line_out_o  (line_out_o)
    );

    sirq_slot_timer #(
        .NSLOT (NSLOT),
        .IW    (IW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (tmr_run),
        .sample_o (tmr_sample),
        .slot_o   (tmr_slot),
        .last_o   (tmr_last)
    );

    sirq_vec_capture #(
        .NSLOT (NSLOT),
        .IW    (IW)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .sample_i (tmr_sample),
        .slot_i   (tmr_slot),
        .commit_i (vec_commit),
        .vec_o    (irq_vec_o)
    );

endmodule

// File: rtl/sirq_host_ctrl_chk.sv
module sirq_host_ctrl_chk
    import sirq_host_pkg::*;
#(
    parameter int NSLOT = 16,
    parameter int EXT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_i,
    input logic             line_oe_o,
    input logic             line_out_o,
    input logic [NSLOT-1:0] irq_vec_o,
    input sirq_state_e      st,
    input logic             quiet_q,
    input logic             smp,
    input logic             last
);

    localparam int LW     = EXT_W + 2;
    localparam int MAXLOW = 2 ** EXT_W;

    logic [LW-1:0] lowrun_q;

    // consecutive clocks the host has driven low so far
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowrun_q <= '0;
        end else if (line_oe_o && !line_out_o) begin
            lowrun_q <= lowrun_q + 1'b1;
        end else begin
            lowrun_q <= '0;
        end
    end

    // R2: a driven-high clock is never followed by another
    a_r2_single_high: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_o && line_out_o) |=> !(line_oe_o && line_out_o));

    // R3: no host low run exceeds the largest start extension plus one
    a_r3_low_max: assert property (@(posedge clk) disable iff (!rst_n)
        lowrun_q <= LW'(MAXLOW));

    // R8: every low run ending in a high clock is at least two clocks long
    a_r8_low_min: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_o && line_out_o && (lowrun_q != '0)) |-> (lowrun_q >= LW'(2)));

    // R4: an agent low while idle in quiet mode is taken over next clock
    a_r4_takeover: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && quiet_q && !line_i) |=> (line_oe_o && !line_out_o));

    // R5: slots are sampled only while the host leaves the line released
    a_r5_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
        smp |-> !line_oe_o);

    // R7: the vector moves only after the last slot clock
    a_r7_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(irq_vec_o));

    // R9: the captured mode moves only after the last slot clock
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(quiet_q));

    // R10: in continuous mode a new start follows the stop's high clock
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_STOP_HI) && !quiet_q) |=> (line_oe_o && !line_out_o));

endmodule

bind sirq_host_ctrl sirq_host_ctrl_chk #(
    .NSLOT (NSLOT),
    .EXT_W (EXT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (line_i),
    .line_oe_o  (line_oe_o),
    .line_out_o (line_out_o),
    .irq_vec_o  (irq_vec_o),
    .st         (seq_state),
    .quiet_q    (seq_quiet),
    .smp        (tmr_sample),
    .last       (tmr_last)
);

// File: tb/sirq_host_ctrl_test.sv
`timescale 1ns/1ps
module sirq_host_ctrl_test;

    localparam int NSLOT = 16;
    localparam int EXT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_i = 1'b1;
    logic [EXT_W-1:0] start_ext_i = '0;
    logic             quiet_mode_i = 1'b0;
    logic             line_oe_o;
    logic             line_out_o;
    logic [NSLOT-1:0] irq_vec_o;

    always #2.5 clk = ~clk;

    sirq_host_ctrl #(.NSLOT(NSLOT), .EXT_W(EXT_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .start_ext_i  (start_ext_i),
        .quiet_mode_i (quiet_mode_i),
        .line_oe_o    (line_oe_o),
        .line_out_o   (line_out_o),
        .irq_vec_o    (irq_vec_o)
    );

    // expected wire activity for one clock; flg: 0 plain, 1 last slot, 2 stop high, 3 idle
    typedef struct {
        bit    oe;
        bit    hi;
        int    smp;
        int    flg;
        string tag;
    } ent_t;

    ent_t             q[$];
    ent_t             cur;
    int               checks = 0;
    int               errors = 0;
    bit               done = 0;
    logic [NSLOT-1:0] shadow_m = '1;
    logic [NSLOT-1:0] vec_m = '1;
    bit               quiet_m = 0;
    int               last_flg = 0;

    // stimulus controls
    logic [NSLOT-1:0] pat = '1;
    int               ext_sel = 3;
    bit               q_last = 0;
    bit               q_other = 0;
    bit               req = 0;
    bit               noise = 0;
    string            scen = "R1 reset";

    task automatic check(string tag, string what, logic [NSLOT-1:0] act, logic [NSLOT-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] %s: actual %h expected %h", tag, scen, what, act, exp);
        end
    endtask

    task automatic push(bit oe, bit hi, int smp, int flg, string tag);
        ent_t e;
        e.oe = oe; e.hi = hi; e.smp = smp; e.flg = flg; e.tag = tag;
        q.push_back(e);
    endtask

    // low part of L clocks, one high clock, then the released slot clocks
    task automatic push_frame(int low_len, string tag);
        for (int i = 0; i < low_len; i++) push(1, 0, -1, 0, tag);
        push(1, 1, -1, 0, tag);
        for (int t = 1; t <= 3 * NSLOT + 1; t++) begin
            int s;
            s = (((t + 1) % 3) == 0) ? ((t + 1) / 3 - 1) : -1;
            push(0, 0, s, (t == 3 * NSLOT + 1) ? 1 : 0, "R5");
        end
    endtask

    function automatic int eff_ext(int v);
        return (v < 3) ? 3 : v;
    endfunction

    task automatic model_advance();
        int e;
        e = eff_ext(int'(start_ext_i));
        if (cur.smp >= 0) shadow_m[cur.smp] = line_i;
        if (cur.flg == 1) begin
            vec_m   = shadow_m;
            quiet_m = quiet_mode_i;
            for (int i = 0; i < (quiet_m ? 2 : 3); i++) push(1, 0, -1, 0, "R8");
            push(1, 1, -1, 2, "R8");
        end
        if (cur.flg == 2 && !quiet_m) push_frame(e + 1, "R10");
        if (cur.flg == 3 && q.size() == 0) begin
            if (!quiet_m) push_frame(e + 1, (start_ext_i < 3) ? "R3" : "R2");
            else if (!line_i) push_frame(e, (start_ext_i < 3) ? "R3" : "R4");
        end
        if (q.size() == 0) begin
            cur.oe = 0; cur.hi = 0; cur.smp = -1; cur.flg = 3; cur.tag = "R11";
        end else begin
            cur = q.pop_front();
        end
    endtask

    task automatic step_cycle();
        bit agent_low;
        @(negedge clk);
        check(cur.tag, "output enable", NSLOT'(line_oe_o), NSLOT'(cur.oe));
        if (cur.oe) check(cur.tag, "driven level", NSLOT'(line_out_o), NSLOT'(cur.hi));
        check("R6,R7", "irq vector", irq_vec_o, vec_m);
        rst_n = 1'b1;
        agent_low = 0;
        if (cur.smp >= 0) agent_low = !pat[cur.smp];
        else if (cur.flg == 3 && req) begin agent_low = 1; req = 0; end
        else if (noise && !cur.oe && cur.flg != 3) agent_low = 1;
        line_i       = line_oe_o ? line_out_o : !agent_low;
        quiet_mode_i = (cur.flg == 1) ? q_last : q_other;
        start_ext_i  = EXT_W'(ext_sel);
        last_flg     = cur.flg;
        model_advance();
    endtask

    task automatic run_frames(int n);
        int seen;
        seen = 0;
        while (seen < n) begin
            step_cycle();
            if (last_flg == 2) seen++;
        end
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) step_cycle();
    endtask

    initial begin
        cur.oe = 0; cur.hi = 0; cur.smp = -1; cur.flg = 3; cur.tag = "R1";
        repeat (3) begin
            @(negedge clk);
            check("R1", "output enable in reset", NSLOT'(line_oe_o), '0);
            check("R1", "vector in reset", irq_vec_o, '1);
        end
        // R2 R5 R6 R8 R10: continuous cycles from reset
        scen = "R2 continuous"; ext_sel = 3; pat = 16'hA5F0;
        run_frames(2);
        // R3: short codes clamp, longest extension
        scen = "R3 clamp"; ext_sel = 0; pat = 16'h3C69;
        run_frames(2);
        scen = "R3 max"; ext_sel = 7; pat = 16'hFFFE;
        run_frames(1);
        // R6: lows outside sample clocks are ignored
        scen = "R6 noise"; noise = 1; ext_sel = 4; pat = 16'h7FFF;
        run_frames(2);
        noise = 0;
        // R9: mode flips everywhere except the capture clock
        scen = "R9 mode held"; q_other = 1; q_last = 0; pat = 16'h0F0F;
        run_frames(2);
        // R7 R9: commit and mode capture in the same clock
        scen = "R7 R9 collision"; q_other = 0; q_last = 1; pat = 16'h1234;
        run_frames(1);
        // R11: quiet idle, mode input ignored while resting
        scen = "R11 quiet idle"; q_other = 0; q_last = 0;
        run_cycles(25);
        // R4: agent start is taken over
        scen = "R4 takeover"; q_other = 1; q_last = 1; ext_sel = 5; pat = 16'hC3A5; req = 1;
        run_frames(1);
        run_cycles(10);
        scen = "R4 clamp takeover"; ext_sel = 1; pat = 16'h0000; req = 1; noise = 1;
        run_frames(1);
        noise = 0;
        run_cycles(6);
        // R10: back to continuous from a quiet-mode takeover
        scen = "R10 return"; ext_sel = 6; pat = 16'hFFFF; q_last = 0; q_other = 0; req = 1;
        run_frames(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule